// File: doc/BRIEF.md
# Control-Register Bus Target Register Bank

This block is the target side of a four-strobe control-register bus. A master selects a register by presenting a 16-bit address on the shared data-in bus and pulsing a capture-address strobe. It stages a 16-bit word the same way with a capture-data strobe. A write strobe then commits the staged word to the selected register, and a read strobe returns the selected register's contents on a data-out bus.

Each strobe is answered with a four-phase acknowledge. The ack rises after a programmable response latency. It stays high while the master holds the strobe, and it drops once the strobe is released. The latency parameter lets a master's timeout logic be exercised against a slow target.

The bank holds a sparse set of implemented 16-bit registers. Their addresses and reset values are parameters. Any address outside that set reads as zero and silently discards writes.

Top module: `crb_target_bank`

## Requirements
- R1: After reset, ack and data-out are 0, and the implemented registers hold their reset values: 0x0030=0x0080, 0x1002=0x1234, 0x1006=0x0040, 0x1010=0x0A5A, 0x102D=0x0003.
- R2: A capture-address strobe latches data-in as the current address, which selects the register for later reads and writes.
- R3: A capture-data strobe latches data-in as the pending word and leaves every register unchanged.
- R4: A write strobe stores the pending word into the register at the current address.
- R5: A read strobe loads the selected register onto data-out no later than the cycle in which ack rises. Data-out then holds that value until the next read.
- R6: If a strobe is sampled high while the target is idle at clock edge k, ack is high from edge k+1+ACK_LATENCY onward. With the default latency of 2, the first sample after the strobe is raised counts as 1, and ack is first seen high on sample 4.
- R7: Ack stays high for as long as the acknowledged strobe stays high. It falls at the first clock edge that samples that strobe low.
- R8: Any strobe change made between recognition of a strobe and the return of ack to low is ignored. This covers data-in changes and extra strobes.
- R9: A write to an address outside the implemented set changes no register, and a read of such an address returns 0.
- R10: When several strobes are sampled high together, only one is served, in the priority order capture-address, capture-data, write, read.
- R11: The current address and the pending word persist across transactions. Repeated writes reuse them without being captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_din | input | 16 | Address or data word from the master |
| cr_cap_addr | input | 1 | Capture-address strobe |
| cr_cap_data | input | 1 | Capture-data strobe |
| cr_wr | input | 1 | Write-commit strobe |
| cr_rd | input | 1 | Read strobe |
| cr_dout | output | 16 | Read data |
| cr_ack | output | 1 | Four-phase acknowledge |

## Verification
The hardest cases to reach from the ports are the ones where the master misbehaves while a handshake is in progress. Examples are changing data-in and pulsing a second strobe while ack is already high, or raising two strobes in the same cycle. The bench holds one strobe high until ack rises, then disturbs the bus before releasing the strobe. It afterwards reads back both the touched and the untouched registers to show that the intruding strobe had no effect. For the simultaneous case it raises capture-address and capture-data together, then performs a write. The written value shows which strobe was served.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADDR  = 3'd1,
        OP_DATA  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4
    } crb_op_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic wr;
        logic rd;
    } crb_strobes_t;

    localparam int unsigned DEF_NREGS = 5;
    localparam logic [DEF_NREGS*WORD_W-1:0] DEF_ADDR_MAP =
        {16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030};
    localparam logic [DEF_NREGS*WORD_W-1:0] DEF_RESET_MAP =
        {16'h0003, 16'h0A5A, 16'h0040, 16'h1234, 16'h0080};

    // Fixed priority: address capture first, read last.
    function automatic crb_op_e pick_op(crb_strobes_t s);
        if (s.cap_addr)      return OP_ADDR;
        else if (s.cap_data) return OP_DATA;
        else if (s.wr)       return OP_WRITE;
        else if (s.rd)       return OP_READ;
        else                 return OP_NONE;
    endfunction

    function automatic logic strobe_of(crb_op_e op, crb_strobes_t s);
        case (op)
            OP_ADDR:  return s.cap_addr;
            OP_DATA:  return s.cap_data;
            OP_WRITE: return s.wr;
            OP_READ:  return s.rd;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/crb_handshake.sv
module crb_handshake
    import crb_pkg::*;
#(
    parameter int unsigned ACK_LATENCY = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  crb_strobes_t strobes,
    output logic         fire,
    output crb_op_e      fire_op,
    output logic         ack
);
    localparam int unsigned CW = (ACK_LATENCY > 0) ? $clog2(ACK_LATENCY + 1) : 1;

    hs_state_e state_q;
    crb_op_e   op_q;
    logic [CW-1:0] cnt_q;
    crb_op_e   op_now;

    always_comb begin
        op_now  = pick_op(strobes);
        fire    = (state_q == HS_IDLE) && (op_now != OP_NONE);
        fire_op = op_now;
        ack     = (state_q == HS_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            op_q    <= OP_NONE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                HS_IDLE: if (fire) begin
                    state_q <= HS_WAIT;
                    op_q    <= op_now;
                    cnt_q   <= '0;
                end
                HS_WAIT: begin
                    if (cnt_q == CW'(ACK_LATENCY)) state_q <= HS_HOLD;
                    else                           cnt_q   <= cnt_q + 1'b1;
                end
                HS_HOLD: if (!strobe_of(op_q, strobes)) state_q <= HS_IDLE;
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    // Independent latency observer for the ack timing check.
    int unsigned since_fire;
    always_ff @(posedge clk) begin
        if (rst)                                 since_fire <= 0;
        else if (fire)                           since_fire <= 1;
        else if (!ack && since_fire < 1000)      since_fire <= since_fire + 1;
    end

    a_r6_ack_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> since_fire == ACK_LATENCY + 2);
    a_r7_ack_held: assert property (@(posedge clk) disable iff (rst)
        (ack && strobe_of(op_q, strobes)) |=> ack);
    a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (ack && !strobe_of(op_q, strobes)) |=> !ack);
    a_r8_no_fire_while_ack: assert property (@(posedge clk) disable iff (rst)
        ack |-> !fire);
    a_r6_no_early_ack: assert property (@(posedge clk) disable iff (rst)
        fire |=> !ack);

endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
    import crb_pkg::*;
#(
    parameter int unsigned NREGS = DEF_NREGS,
    parameter logic [NREGS*WORD_W-1:0] ADDR_MAP  = DEF_ADDR_MAP,
    parameter logic [NREGS*WORD_W-1:0] RESET_MAP = DEF_RESET_MAP
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  crb_op_e fire_op,
    input  word_t   din,
    output word_t   rdata,
    output logic    hit
);
    word_t addr_q;
    word_t data_q;
    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (fire) begin
            if (fire_op == OP_ADDR) addr_q <= din;
            if (fire_op == OP_DATA) data_q <= din;
        end
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam word_t MY_ADDR  = ADDR_MAP[i*WORD_W +: WORD_W];
        localparam word_t MY_RESET = RESET_MAP[i*WORD_W +: WORD_W];
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= MY_RESET;
            else if (fire && fire_op == OP_WRITE && addr_q == MY_ADDR)
                regs[i] <= data_q;
        end
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < NREGS; i++) begin
            if (addr_q == ADDR_MAP[i*WORD_W +: WORD_W]) begin
                rdata = rdata | regs[i];
                hit   = 1'b1;
            end
        end
    end

    a_r4_write_commits: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_op == OP_WRITE && hit) |=> rdata == $past(data_q));
    a_r3_capture_keeps_reg: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_op == OP_DATA) |=> $stable(rdata));

endmodule

// File: rtl/crb_target_bank.sv
module crb_target_bank
    import crb_pkg::*;
#(
    parameter int unsigned ACK_LATENCY = 2,
    parameter int unsigned NREGS = DEF_NREGS,
    parameter logic [NREGS*WORD_W-1:0] ADDR_MAP  = DEF_ADDR_MAP,
    parameter logic [NREGS*WORD_W-1:0] RESET_MAP = DEF_RESET_MAP
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cr_din,
    input  logic        cr_cap_addr,
    input  logic        cr_cap_data,
    input  logic        cr_wr,
    input  logic        cr_rd,
    output logic [15:0] cr_dout,
    output logic        cr_ack
);
    crb_strobes_t strobes;
    logic    fire;
    crb_op_e fire_op;
    word_t   rdata;
    logic    hit;
    word_t   dout_q;

    assign strobes = '{cap_addr: cr_cap_addr, cap_data: cr_cap_data,
                       wr: cr_wr, rd: cr_rd};

    crb_handshake #(.ACK_LATENCY(ACK_LATENCY)) u_hs (
        .clk(clk), .rst(rst), .strobes(strobes),
        .fire(fire), .fire_op(fire_op), .ack(cr_ack)
    );

    crb_regfile #(.NREGS(NREGS), .ADDR_MAP(ADDR_MAP), .RESET_MAP(RESET_MAP)) u_rf (
        .clk(clk), .rst(rst), .fire(fire), .fire_op(fire_op),
        .din(cr_din), .rdata(rdata), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst)                          dout_q <= '0;
        else if (fire && fire_op == OP_READ) dout_q <= rdata;
    end

    assign cr_dout = dout_q;

    a_r9_unimpl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_op == OP_READ && !hit) |=> cr_dout == '0);
    a_r5_dout_holds: assert property (@(posedge clk) disable iff (rst)
        !(fire && fire_op == OP_READ) |=> $stable(cr_dout));

endmodule

// File: tb/crb_target_bank_bench.sv
module crb_target_bank_bench;
    localparam int LAT = 2;

    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cr_din = '0;
    logic        cr_cap_addr = 0, cr_cap_data = 0, cr_wr = 0, cr_rd = 0;
    logic [15:0] cr_dout;
    logic        cr_ack;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    crb_target_bank #(.ACK_LATENCY(LAT)) u_crb_target_bank (
        .clk(clk), .rst(rst), .cr_din(cr_din),
        .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
        .cr_wr(cr_wr), .cr_rd(cr_rd), .cr_dout(cr_dout), .cr_ack(cr_ack)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_strobe(input int kind, input logic v);
        case (kind)
            1: cr_cap_addr = v;
            2: cr_cap_data = v;
            3: cr_wr       = v;
            default: cr_rd = v;
        endcase
    endtask

    // kind: 1 address, 2 data, 3 write, 4 read
    task automatic bus_op(input int kind, input logic [15:0] v,
                          output logic [15:0] rd, output int lat);
        lat = 0;
        @(negedge clk);
        cr_din = v;
        set_strobe(kind, 1'b1);
        do begin
            @(negedge clk);
            lat++;
        end while (!cr_ack && lat < 100);
        if (lat >= 100) check("watchdog", 16'd1, 16'd0);
        rd = cr_dout;
        set_strobe(kind, 1'b0);
        for (int i = 0; i < 100 && cr_ack; i++) @(negedge clk);
        if (cr_ack) check("watchdog", 16'd1, 16'd0);
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [15:0] d);
        int l;
        logic [15:0] x;
        bus_op(1, a, x, l);
        bus_op(4, 16'h0, d, l);
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
        int l;
        logic [15:0] x;
        bus_op(1, a, x, l);
        bus_op(2, d, x, l);
        bus_op(3, 16'h0, x, l);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 ack", {15'd0, cr_ack}, 16'd0);
        check("R1 dout", cr_dout, 16'h0);
        rd_reg(16'h0030, d); check("R1 0x0030", d, 16'h0080);
        rd_reg(16'h1002, d); check("R1 0x1002", d, 16'h1234);
        rd_reg(16'h1006, d); check("R1 0x1006", d, 16'h0040);
        rd_reg(16'h1010, d); check("R1 0x1010", d, 16'h0A5A);
        rd_reg(16'h102D, d); check("R1 0x102D", d, 16'h0003);
    endtask

    task automatic t_latency;
        logic [15:0] x;
        int l;
        bus_op(1, 16'h1002, x, l);
        check("R6 latency addr", 16'(l), 16'(LAT + 2));
        bus_op(4, 16'h0, x, l);
        check("R6 latency read", 16'(l), 16'(LAT + 2));
        check("R5 data at ack", x, 16'h1234);
    endtask

    task automatic t_write;
        logic [15:0] d, x;
        int l;
        wr_reg(16'h1002, 16'hBEEF);
        rd_reg(16'h1002, d); check("R4 write 0x1002", d, 16'hBEEF);
        bus_op(1, 16'h1006, x, l);
        bus_op(2, 16'h7777, x, l);
        bus_op(4, 16'h0, d, l); check("R3 capture only", d, 16'h0040);
        bus_op(1, 16'h0030, x, l);
        check("R5 dout holds", cr_dout, 16'h0040);
        bus_op(4, 16'h0, d, l); check("R2 address select", d, 16'h0080);
    endtask

    task automatic t_reuse;
        logic [15:0] d, x;
        int l;
        wr_reg(16'h0030, 16'h1111);
        bus_op(2, 16'h2222, x, l);
        bus_op(3, 16'h0, x, l);
        bus_op(4, 16'h0, d, l); check("R11 same address", d, 16'h2222);
        bus_op(1, 16'h1010, x, l);
        bus_op(3, 16'h0, x, l);
        bus_op(4, 16'h0, d, l); check("R11 same data", d, 16'h2222);
    endtask

    task automatic t_unimpl;
        logic [15:0] d;
        wr_reg(16'h0031, 16'h5555);
        rd_reg(16'h0031, d); check("R9 unimpl read", d, 16'h0000);
        rd_reg(16'h0030, d); check("R9 neighbour", d, 16'h2222);
        rd_reg(16'h102D, d); check("R9 other reg", d, 16'h0003);
    endtask

    task automatic t_hold;
        int l = 0;
        @(negedge clk);
        cr_din = 16'h102D;
        cr_cap_addr = 1;
        while (!cr_ack && l < 100) begin @(negedge clk); l++; end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R7 ack held", {15'd0, cr_ack}, 16'd1);
        end
        cr_cap_addr = 0;
        @(negedge clk);
        check("R7 ack falls", {15'd0, cr_ack}, 16'd0);
        @(negedge clk);
    endtask

    task automatic t_busy;
        logic [15:0] d, x;
        int l = 0;
        wr_reg(16'h1006, 16'hA1A1);
        @(negedge clk);
        cr_din = 16'h1006;
        cr_cap_addr = 1;
        @(negedge clk);
        cr_din = 16'h1010;           // change during latency
        while (!cr_ack && l < 100) begin @(negedge clk); l++; end
        cr_wr = 1;                   // intruding strobe while ack high
        @(negedge clk);
        cr_wr = 0;
        cr_cap_addr = 0;
        @(negedge clk);
        @(negedge clk);
        bus_op(4, 16'h0, d, l); check("R8 address kept", d, 16'hA1A1);
        rd_reg(16'h1010, d); check("R8 no write", d, 16'h2222);
        x = d;
    endtask

    task automatic t_prio;
        logic [15:0] d, x;
        int l = 0;
        @(negedge clk);
        cr_din = 16'h1002;
        cr_cap_addr = 1;
        cr_cap_data = 1;
        while (!cr_ack && l < 100) begin @(negedge clk); l++; end
        cr_cap_addr = 0;
        cr_cap_data = 0;
        @(negedge clk);
        @(negedge clk);
        bus_op(3, 16'h0, x, l);      // pending word is still 0xA1A1
        bus_op(4, 16'h0, d, l);
        check("R10 priority", d, 16'hA1A1);
    endtask

    initial begin
        int wd = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset();
                t_latency();
                t_write();
                t_reuse();
                t_unimpl();
                t_hold();
                t_busy();
                t_prio();
            end
            begin
                while (wd < 100000) begin @(negedge clk); wd++; end
                check("watchdog", 16'd1, 16'd0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule